// File: doc/BRIEF.md
# Fixed-Point YCbCr to RGB Converter

This block turns one signed luma sample and two signed chroma samples into red, green and blue components. The arithmetic is deliberately narrow: each chroma contribution is formed as a product with a 10-bit-fraction constant. Each product is then floored on its own before it meets the luma value. This narrow arithmetic reproduces the overflow and rounding quirks of a low-precision colour stage, bit for bit.

The four constants are 1436 (Cr into red), -732 (Cr into green), -352 (Cb into green) and 1816 (Cb into blue), all scaled by 1/1024. They equal 5744, -2928, -1408 and 7264 over 4096, so the result is the same as with a 12-bit fraction. Each sum is clamped to the signed 8-bit range. A per-sample format bit can shift the clamped result into the unsigned 0..255 range.

The result appears one clock after the input strobe, with its own strobe. Between strobes the outputs keep their last value.

Top module: `ycc2rgb_conv`

## Requirements
- R1: After reset, valid_o, r_o, g_o and b_o are 0. valid_o equals the valid_i of the previous clock edge, so a result appears one cycle after its input.
- R2: The red channel is clamp(Y + floor(1436*Cr/1024)).
- R3: The green channel is clamp(Y + floor(-352*Cb/1024) + floor(-732*Cr/1024)). The two terms are each floored separately before the add.
- R4: The blue channel is clamp(Y + floor(1816*Cb/1024)).
- R5: clamp() limits the sum to -128..127. Results above the range give 127, and results below it give -128.
- R6: When unsigned_i is 1 with the sample, each output is the clamped value plus 128, which is the sign bit inverted. When unsigned_i is 0, each output is the two's-complement clamped value.
- R7: While valid_i is 0, r_o, g_o and b_o keep their previous values whatever the data inputs do.
- R8: Every chroma product is rounded toward negative infinity, so a negative product with a nonzero fraction loses one more unit. For example, Cr = -1 gives a red term of -2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| y_i | input | 8 | Luma, signed |
| cb_i | input | 8 | Blue-difference chroma, signed |
| cr_i | input | 8 | Red-difference chroma, signed |
| unsigned_i | input | 1 | 1: offset outputs by +128 |
| valid_o | output | 1 | Output strobe |
| r_o | output | 8 | Red |
| g_o | output | 8 | Green |
| b_o | output | 8 | Blue |

## Verification
Directed vectors come first. Small negative chroma values separate floor rounding from truncation toward zero. Extreme chroma at extreme luma drives every channel into both clamp limits. Mixed-sign Cb and Cr separate separate flooring of the green terms from flooring their sum. A full sweep of every Cb and Cr pair follows, with luma tied to a function of the pair, in both output formats. It compares every result against an integer model and exposes any wrong coefficient, any wrong shift or any wrong clamp. Idle cycles with changing data show whether the output register loads without a strobe.

// File: rtl/ycc2rgb_pkg.sv
package ycc2rgb_pkg;
  localparam int IN_W   = 8;
  localparam int OUT_W  = 8;
  localparam int FRAC_W = 10;
  localparam int COEF_W = 12;
  localparam int N_TERM = 4;
  localparam int PROD_W = IN_W + COEF_W;
  localparam int TERM_W = PROD_W - FRAC_W;
  localparam int SUM_W  = TERM_W + 2;

  // term order: cr->r, cr->g, cb->g, cb->b
  localparam int COEF_TAB [N_TERM] = '{1436, -732, -352, 1816};
  localparam bit USE_CR   [N_TERM] = '{1'b1, 1'b1, 1'b0, 1'b0};
endpackage

// File: rtl/ycc2rgb_term.sv
module ycc2rgb_term
  import ycc2rgb_pkg::*;
#(
  parameter int COEF = 1436
) (
  input  logic signed [IN_W-1:0]   x_i,
  output logic signed [TERM_W-1:0] t_o
);
  localparam logic signed [COEF_W-1:0] K = COEF_W'(COEF);

  logic signed [PROD_W-1:0] prod;

  assign prod = x_i * K;
  // dropping low bits of a two's-complement value floors it
  assign t_o  = prod[PROD_W-1:FRAC_W];

  always_comb begin
    // R8
    if ((x_i < 0) && (COEF > 0)) floor_neg_chk: assert (t_o < 0);
    if (x_i == 0) zero_term_chk: assert (t_o == 0);
  end
endmodule

// File: rtl/ycc2rgb_chan.sv
module ycc2rgb_chan
  import ycc2rgb_pkg::*;
#(
  parameter int NT = 1
) (
  input  logic signed [IN_W-1:0]             y_i,
  input  logic        [NT-1:0][TERM_W-1:0]   terms_i,
  output logic signed [OUT_W-1:0]            sat_o
);
  localparam int MAX_V = (1 << (OUT_W - 1)) - 1;
  localparam int MIN_V = -(1 << (OUT_W - 1));
  localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'(MAX_V);
  localparam logic signed [SUM_W-1:0] MIN_S = SUM_W'(MIN_V);

  logic signed [SUM_W-1:0] sum;

  always_comb begin
    sum = SUM_W'(y_i);
    for (int i = 0; i < NT; i++) begin
      sum = sum + SUM_W'($signed(terms_i[i]));
    end
  end

  always_comb begin
    if (sum > MAX_S)      sat_o = OUT_W'(MAX_V);
    else if (sum < MIN_S) sat_o = OUT_W'(MIN_V);
    else                  sat_o = sum[OUT_W-1:0];
  end

  always_comb begin
    // R5
    if (sum > MAX_S) clamp_hi_chk: assert (sat_o == OUT_W'(MAX_V));
    // R5
    if (sum < MIN_S) clamp_lo_chk: assert (sat_o == OUT_W'(MIN_V));
  end
endmodule

// File: rtl/ycc2rgb_conv.sv
module ycc2rgb_conv
  import ycc2rgb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IN_W-1:0]  y_i,
  input  logic [IN_W-1:0]  cb_i,
  input  logic [IN_W-1:0]  cr_i,
  input  logic             unsigned_i,
  output logic             valid_o,
  output logic [OUT_W-1:0] r_o,
  output logic [OUT_W-1:0] g_o,
  output logic [OUT_W-1:0] b_o
);
  logic [N_TERM-1:0][TERM_W-1:0] term;
  logic signed [OUT_W-1:0] r_sat, g_sat, b_sat;
  logic [OUT_W-1:0] msb_flip;

  for (genvar k = 0; k < N_TERM; k++) begin : g_term
    logic signed [TERM_W-1:0] t;
    ycc2rgb_term #(.COEF(COEF_TAB[k])) u_term (
      .x_i ($signed(USE_CR[k] ? cr_i : cb_i)),
      .t_o (t)
    );
    assign term[k] = t;
  end

  ycc2rgb_chan #(.NT(1)) u_chan_r (
    .y_i (y_i), .terms_i (term[0]), .sat_o (r_sat)
  );
  ycc2rgb_chan #(.NT(2)) u_chan_g (
    .y_i (y_i), .terms_i ({term[2], term[1]}), .sat_o (g_sat)
  );
  ycc2rgb_chan #(.NT(1)) u_chan_b (
    .y_i (y_i), .terms_i (term[3]), .sat_o (b_sat)
  );

  // +2^(OUT_W-1) offset equals inverting the sign bit
  assign msb_flip = {unsigned_i, {(OUT_W-1){1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      r_o     <= '0;
      g_o     <= '0;
      b_o     <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        r_o <= r_sat ^ msb_flip;
        g_o <= g_sat ^ msb_flip;
        b_o <= b_sat ^ msb_flip;
      end
    end
  end

  // R1
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R1
  valid_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(r_o) && $stable(g_o) && $stable(b_o)));
  // R6
  unsigned_r_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && unsigned_i && (r_sat == -8'sd128)) |=> (r_o == 8'd0));
endmodule

// File: tb/ycc2rgb_conv_tb.sv
module ycc2rgb_conv_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid_i = 1'b0;
  logic [7:0] y_i = '0, cb_i = '0, cr_i = '0;
  logic unsigned_i = 1'b0;
  logic valid_o;
  logic [7:0] r_o, g_o, b_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ycc2rgb_conv u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .y_i(y_i), .cb_i(cb_i), .cr_i(cr_i), .unsigned_i(unsigned_i),
    .valid_o(valid_o), .r_o(r_o), .g_o(g_o), .b_o(b_o)
  );

  function automatic int clamp8(int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic int fl10(int p);
    return p >>> 10;
  endfunction

  function automatic logic [7:0] fmt(int v, bit u);
    return u ? 8'(v + 128) : 8'(v);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // drive at negedge, result registered at next posedge, sample at the negedge after
  task automatic apply(string tag, int y, int cb, int cr, bit u);
    int er, eg, eb;
    @(negedge clk);
    valid_i = 1'b1; y_i = 8'(y); cb_i = 8'(cb); cr_i = 8'(cr); unsigned_i = u;
    er = clamp8(y + fl10(1436 * cr));
    eg = clamp8(y + fl10(-352 * cb) + fl10(-732 * cr));
    eb = clamp8(y + fl10(1816 * cb));
    @(negedge clk);
    valid_i = 1'b0;
    check({tag, " valid R1"}, 32'(valid_o), 32'd1);
    check({tag, " rgb R2 R3 R4"}, {8'h0, r_o, g_o, b_o},
          {8'h0, fmt(er, u), fmt(eg, u), fmt(eb, u)});
  endtask

  task automatic t_reset();
    check("reset R1", {7'h0, valid_o, r_o, g_o, b_o}, 32'h0);
  endtask

  task automatic t_floor();
    apply("floor R8 cr=-1", 0, 0, -1, 1'b0);
    n_chk++;
    if (r_o !== 8'hFE) begin
      n_fail++; $display("FAIL R8 act=%0h exp=fe", r_o);
    end
    apply("floor R8 cb=-1", 0, -1, 0, 1'b0);
    apply("floor R3 mixed", 5, 3, -3, 1'b0);
    apply("floor R3 mixed2", -7, -5, 9, 1'b0);
  endtask

  task automatic t_clamp();
    apply("clamp R5 hi", 127, 127, 127, 1'b0);
    n_chk++;
    if ({r_o, b_o} !== 16'h7F7F) begin
      n_fail++; $display("FAIL R5 act=%0h exp=7f7f", {r_o, b_o});
    end
    apply("clamp R5 lo", -128, -128, -128, 1'b0);
    n_chk++;
    if ({r_o, b_o} !== 16'h8080) begin
      n_fail++; $display("FAIL R5 act=%0h exp=8080", {r_o, b_o});
    end
    apply("clamp R5 g hi", 127, -128, -128, 1'b0);
    apply("clamp R5 g lo", -128, 127, 127, 1'b0);
  endtask

  task automatic t_unsigned();
    apply("unsigned R6 zero", 0, 0, 0, 1'b1);
    n_chk++;
    if ({r_o, g_o, b_o} !== 24'h808080) begin
      n_fail++; $display("FAIL R6 act=%0h exp=808080", {r_o, g_o, b_o});
    end
    apply("unsigned R6 lo", -128, -128, -128, 1'b1);
    apply("unsigned R6 hi", 127, 127, 127, 1'b1);
  endtask

  task automatic t_hold();
    logic [23:0] last;
    apply("hold R7 load", 40, -20, 30, 1'b0);
    last = {r_o, g_o, b_o};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      y_i = 8'(i * 37); cb_i = 8'(i * 91); cr_i = 8'(-i * 53); unsigned_i = i[0];
    end
    @(negedge clk);
    check("hold R7", {8'h0, {r_o, g_o, b_o}}, {8'h0, last});
    check("hold R1 valid low", 32'(valid_o), 32'd0);
  endtask

  task automatic t_sweep();
    for (int cb = -128; cb < 128; cb++) begin
      for (int cr = -128; cr < 128; cr++) begin
        int y;
        y = ((cb * 7) ^ (cr * 3)) % 256;
        if (y > 127) y -= 256;
        if (y < -128) y += 256;
        apply("sweep R2 R3 R4 R6", y, cb, cr, bit'((cb ^ cr) & 1));
      end
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_floor();
    t_clamp();
    t_unsigned();
    t_hold();
    t_sweep();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule